// File: doc/BRIEF.md
# Threshold Window Comparator with Hysteresis

This block watches a stream of measurement results. Each result arrives as a 24-bit value together with a one-cycle valid strobe. The block compares the value with a programmable low threshold and a programmable high threshold. A 3-bit mode input picks the comparison rule. Two of the rules are hysteretic: they trip on one threshold and release on the other, so a value that hovers near a single limit does not make the output chatter.

When a strobed value satisfies the active rule, the block sets a sticky interrupt flag. It can also emit a one-cycle event pulse for downstream logic. The flag is cleared by a write-one-to-clear strobe. A separate interrupt enable, armed and disarmed through set and clear strobes, decides whether the flag reaches the interrupt line. The current match state is visible at all times, and software or a sequencer can use it to follow the hysteresis band.

Top module: `window_monitor`

## Requirements
- R1: After reset, winFlag, winEvent, matchNow and irq are all 0, and the interrupt enable is off.
- R2: Only bits 23:0 of resultValue, lowThresh and highThresh take part in comparisons. Bits 31:24 have no effect.
- R3: With modeSel = 0 the monitor is off. No strobe sets winFlag or produces winEvent, and matchNow reads 0.
- R4: Mode 1 matches when value > low threshold. Mode 2 matches when value < high threshold. All comparisons are unsigned and strict, so equality never counts.
- R5: Mode 3 matches when low < value < high. Mode 4 matches when value < low or value > high. Mode 7 never matches.
- R6: Mode 5 begins matching on a value > high and keeps matching on later strobes until a value < low is seen.
- R7: Mode 6 begins matching on a value < low and keeps matching on later strobes until a value > high is seen.
- R8: The held match/hysteresis state returns to not-matching in the cycle after modeSel changes or while modeSel = 0. A strobe in the same cycle as a mode change is judged from the cleared state.
- R9: winEvent is a one-cycle pulse in the cycle after a matching strobe. It appears only if evtOutEn was 1 during that strobe.
- R10: A matching strobe sets winFlag in the next cycle. The flag stays set until a cycle with flagClr = 1 and no matching strobe. When a set and a clear happen in the same cycle, the set wins.
- R11: irq equals winFlag AND the interrupt enable. intEnSet turns the enable on and intEnClr turns it off. If both arrive in the same cycle, the clear wins.
- R12: Comparisons take effect only in cycles with resultValid = 1. matchNow takes the new result one cycle after the strobe and otherwise holds, except as R8 states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| resultValid | input | 1 | One-cycle strobe marking a new measurement |
| resultValue | input | 32 | Measurement, bits 23:0 used |
| lowThresh | input | 32 | Low threshold, bits 23:0 used |
| highThresh | input | 32 | High threshold, bits 23:0 used |
| modeSel | input | 3 | Comparison rule, 0 = off, 1..6 rules, 7 = never matches |
| evtOutEn | input | 1 | Enables the event pulse output |
| flagClr | input | 1 | Write-one-to-clear strobe for winFlag |
| intEnSet | input | 1 | Turns the interrupt enable on |
| intEnClr | input | 1 | Turns the interrupt enable off |
| winFlag | output | 1 | Sticky window match flag |
| winEvent | output | 1 | One-cycle event pulse on a match |
| matchNow | output | 1 | Current match / hysteresis state |
| irq | output | 1 | Masked interrupt line |

## Verification
The bench uses the default parameters: a 24-bit compare width on a 32-bit register bus. Because the bus is wider, the bench can load garbage into bits 31:24 of values and thresholds and show that those bits are ignored. Random values are drawn next to each threshold (one below, equal, one above) and mixed with some wide draws. This exercises every strict-inequality edge in all eight mode codes. The random phase also changes mode often, so hysteresis clearing on mode changes is hit many times.

// File: rtl/winmon_pkg.sv
package winmon_pkg;

  typedef enum logic [2:0] {
    WM_OFF      = 3'd0,
    WM_ABOVE    = 3'd1,
    WM_BELOW    = 3'd2,
    WM_INSIDE   = 3'd3,
    WM_OUTSIDE  = 3'd4,
    WM_HYST_UP  = 3'd5,
    WM_HYST_DN  = 3'd6,
    WM_RESERVED = 3'd7
  } winMode_t;

  // raw relations between the measurement and each threshold
  typedef struct packed {
    logic gtLow;
    logic ltLow;
    logic gtHigh;
    logic ltHigh;
  } cmpFlags_t;

  // strobes from control to the flag/event datapath
  typedef struct packed {
    logic hit;
    logic fireEvt;
  } ctrlStrobe_t;

endpackage

// File: rtl/winmon_cmp.sv
module winmon_cmp
  import winmon_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int BUS_W  = 32
) (
  input  logic [BUS_W-1:0] value,
  input  logic [BUS_W-1:0] lowThr,
  input  logic [BUS_W-1:0] highThr,
  output cmpFlags_t        rel
);
  logic [DATA_W-1:0] valueCut;
  logic [DATA_W-1:0] lowCut;
  logic [DATA_W-1:0] highCut;

  generate
    if (BUS_W > DATA_W) begin : g_trim
      assign valueCut = value[DATA_W-1:0];
      assign lowCut   = lowThr[DATA_W-1:0];
      assign highCut  = highThr[DATA_W-1:0];
    end else begin : g_direct
      assign valueCut = value;
      assign lowCut   = lowThr;
      assign highCut  = highThr;
    end
  endgenerate

  always_comb begin
    rel.gtLow  = valueCut > lowCut;
    rel.ltLow  = valueCut < lowCut;
    rel.gtHigh = valueCut > highCut;
    rel.ltHigh = valueCut < highCut;
  end
endmodule

// File: rtl/winmon_ctrl.sv
module winmon_ctrl
  import winmon_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        resultValid,
  input  logic [2:0]  modeSel,
  input  logic        evtOutEn,
  input  cmpFlags_t   rel,
  output ctrlStrobe_t strobe,
  output logic        matchNow
);
  winMode_t modeNow;
  winMode_t modeQ;
  logic     matchQ;
  logic     modeChg;
  logic     heldState;
  logic     candidate;
  logic     matchNext;

  assign modeNow = winMode_t'(modeSel);
  assign modeChg = (modeNow != modeQ);
  // cleared hysteresis state on a mode switch or while off
  assign heldState = (modeChg || modeNow == WM_OFF) ? 1'b0 : matchQ;

  always_comb begin
    unique case (modeNow)
      WM_ABOVE:   candidate = rel.gtLow;
      WM_BELOW:   candidate = rel.ltHigh;
      WM_INSIDE:  candidate = rel.gtLow & rel.ltHigh;
      WM_OUTSIDE: candidate = rel.ltLow | rel.gtHigh;
      WM_HYST_UP: candidate = heldState ? ~rel.ltLow : rel.gtHigh;
      WM_HYST_DN: candidate = heldState ? ~rel.gtHigh : rel.ltLow;
      default:    candidate = 1'b0;
    endcase
  end

  assign matchNext      = resultValid ? candidate : heldState;
  assign strobe.hit     = resultValid & candidate;
  assign strobe.fireEvt = resultValid & candidate & evtOutEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= WM_OFF;
      matchQ <= 1'b0;
    end else begin
      modeQ  <= modeNow;
      matchQ <= matchNext;
    end
  end

  assign matchNow = matchQ;
endmodule

// File: rtl/winmon_regs.sv
module winmon_regs
  import winmon_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        flagClr,
  input  logic        intEnSet,
  input  logic        intEnClr,
  output logic        winFlag,
  output logic        winEvent,
  output logic        irq
);
  logic flagQ;
  logic evtQ;
  logic intEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ  <= 1'b0;
      evtQ   <= 1'b0;
      intEnQ <= 1'b0;
    end else begin
      flagQ <= strobe.hit | (flagQ & ~flagClr);
      evtQ  <= strobe.fireEvt;
      if (intEnClr)      intEnQ <= 1'b0;
      else if (intEnSet) intEnQ <= 1'b1;
    end
  end

  assign winFlag  = flagQ;
  assign winEvent = evtQ;
  assign irq      = flagQ & intEnQ;
endmodule

// File: rtl/window_monitor.sv
module window_monitor
  import winmon_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int BUS_W  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             resultValid,
  input  logic [BUS_W-1:0] resultValue,
  input  logic [BUS_W-1:0] lowThresh,
  input  logic [BUS_W-1:0] highThresh,
  input  logic [2:0]       modeSel,
  input  logic             evtOutEn,
  input  logic             flagClr,
  input  logic             intEnSet,
  input  logic             intEnClr,
  output logic             winFlag,
  output logic             winEvent,
  output logic             matchNow,
  output logic             irq
);
  cmpFlags_t   rel;
  ctrlStrobe_t strobe;

  winmon_cmp #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_cmp (
    .value  (resultValue),
    .lowThr (lowThresh),
    .highThr(highThresh),
    .rel    (rel)
  );

  winmon_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .resultValid(resultValid),
    .modeSel    (modeSel),
    .evtOutEn   (evtOutEn),
    .rel        (rel),
    .strobe     (strobe),
    .matchNow   (matchNow)
  );

  winmon_regs u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .flagClr (flagClr),
    .intEnSet(intEnSet),
    .intEnClr(intEnClr),
    .winFlag (winFlag),
    .winEvent(winEvent),
    .irq     (irq)
  );
endmodule

// File: rtl/winmon_checker.sv
module winmon_checker (
  input logic       clk,
  input logic       rstN,
  input logic       resultValid,
  input logic [2:0] modeSel,
  input logic       evtOutEn,
  input logic       flagClr,
  input logic       winFlag,
  input logic       winEvent,
  input logic       matchNow,
  input logic       irq
);
  AST_OFF_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd0 && !winFlag) |=> !winFlag);                     // R3
  AST_OFF_NO_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd0) |=> !winEvent);                                 // R3
  AST_OFF_NO_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd0) |=> !matchNow);                                 // R8
  AST_EVENT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !evtOutEn |=> !winEvent);                                         // R9
  AST_EVENT_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    winEvent |-> $past(resultValid));                                 // R12
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (winFlag && !flagClr) |=> winFlag);                               // R10
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (winFlag && flagClr && !resultValid) |=> !winFlag);               // R10
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    winEvent |-> winFlag);                                            // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> winFlag);                                                 // R11
endmodule

bind window_monitor winmon_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .resultValid(resultValid),
  .modeSel    (modeSel),
  .evtOutEn   (evtOutEn),
  .flagClr    (flagClr),
  .winFlag    (winFlag),
  .winEvent   (winEvent),
  .matchNow   (matchNow),
  .irq        (irq)
);

// File: tb/window_monitor_test.sv
module window_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resultValid = 1'b0;
  logic [31:0] resultValue = '0;
  logic [31:0] lowThresh = '0;
  logic [31:0] highThresh = '0;
  logic [2:0]  modeSel = '0;
  logic        evtOutEn = 1'b0;
  logic        flagClr = 1'b0;
  logic        intEnSet = 1'b0;
  logic        intEnClr = 1'b0;
  logic        winFlag, winEvent, matchNow, irq;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  // reference state
  logic [2:0] mMode  = '0;
  logic       mMatch = 0;
  logic       mFlag  = 0;
  logic       mEvt   = 0;
  logic       mIntEn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  window_monitor uut (
    .clk(clk), .rstN(rstN), .resultValid(resultValid), .resultValue(resultValue),
    .lowThresh(lowThresh), .highThresh(highThresh), .modeSel(modeSel),
    .evtOutEn(evtOutEn), .flagClr(flagClr), .intEnSet(intEnSet), .intEnClr(intEnClr),
    .winFlag(winFlag), .winEvent(winEvent), .matchNow(matchNow), .irq(irq)
  );

  function automatic logic ruleMatch(input logic [2:0] md, input logic [31:0] v,
                                     input logic [31:0] lo, input logic [31:0] hi,
                                     input logic held);
    logic [23:0] a, l, h;
    a = v[23:0]; l = lo[23:0]; h = hi[23:0];
    case (md)
      3'd1: return a > l;
      3'd2: return a < h;
      3'd3: return (a > l) && (a < h);
      3'd4: return (a < l) || (a > h);
      3'd5: return held ? !(a < l) : (a > h);
      3'd6: return held ? !(a > h) : (a < l);
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input string nm, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, nm, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk(tag, "winFlag", winFlag, mFlag);
    chk(tag, "winEvent", winEvent, mEvt);
    chk(tag, "matchNow", matchNow, mMatch);
    chk(tag, "irq", irq, mFlag & mIntEn);
  endtask

  task automatic step(input logic rv, input logic [31:0] v, input logic [2:0] md,
                      input logic clrI, input logic setE, input logic clrE, input string tag);
    logic chg, held, m, hit;
    resultValid = rv; resultValue = v; modeSel = md;
    flagClr = clrI; intEnSet = setE; intEnClr = clrE;
    chg  = (md != mMode);
    held = (chg || md == 3'd0) ? 1'b0 : mMatch;
    m    = ruleMatch(md, v, lowThresh, highThresh, held);
    hit  = rv & m;
    @(posedge clk); #1;
    mMatch = rv ? m : held;
    mEvt   = hit & evtOutEn;
    mFlag  = hit | (mFlag & ~clrI);
    if (clrE) mIntEn = 0; else if (setE) mIntEn = 1;
    mMode  = md;
    checkAll(tag);
  endtask

  // strobe a value in mode md
  task automatic sv(input logic [31:0] v, input logic [2:0] md, input string tag);
    step(1'b1, v, md, 1'b0, 1'b0, 1'b0, tag);
  endtask

  function automatic logic [31:0] pickNear(input logic [31:0] lo, input logic [31:0] hi);
    logic [23:0] base;
    logic [31:0] r;
    r = $urandom;
    case (r % 8)
      0: base = lo[23:0] - 24'd1;
      1: base = lo[23:0];
      2: base = lo[23:0] + 24'd1;
      3: base = hi[23:0] - 24'd1;
      4: base = hi[23:0];
      5: base = hi[23:0] + 24'd1;
      default: base = 24'($urandom);
    endcase
    return {8'($urandom), base};
  endfunction

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    #1;
    checkAll("R1");
    rstN = 1'b1;
    @(posedge clk); #1;
    checkAll("R1");

    lowThresh = 32'd100; highThresh = 32'd200; evtOutEn = 1'b1;
    step(1'b0, 0, 3'd0, 1'b0, 1'b1, 1'b0, "R11");
    // R4 edges
    sv(32'd100, 3'd1, "R4"); sv(32'd101, 3'd1, "R4");
    sv(32'd200, 3'd2, "R4"); sv(32'd199, 3'd2, "R4");
    // R5
    sv(32'd100, 3'd3, "R5"); sv(32'd150, 3'd3, "R5"); sv(32'd200, 3'd3, "R5");
    sv(32'd100, 3'd4, "R5"); sv(32'd99, 3'd4, "R5"); sv(32'd201, 3'd4, "R5");
    sv(32'd200, 3'd4, "R5"); sv(32'd0, 3'd7, "R5"); sv(32'hFFFFFF, 3'd7, "R5");
    // R2: upper garbage ignored
    sv(32'hFF00_0050, 3'd1, "R2");
    lowThresh = 32'hAB00_0064;
    sv(32'h5500_0065, 3'd1, "R2");
    sv(32'h5500_0064, 3'd1, "R2");
    lowThresh = 32'd100;
    // R6
    sv(32'd150, 3'd5, "R6"); sv(32'd200, 3'd5, "R6"); sv(32'd201, 3'd5, "R6");
    sv(32'd150, 3'd5, "R6"); sv(32'd100, 3'd5, "R6"); sv(32'd99, 3'd5, "R6");
    sv(32'd150, 3'd5, "R6");
    // R7
    sv(32'd150, 3'd6, "R7"); sv(32'd99, 3'd6, "R7"); sv(32'd150, 3'd6, "R7");
    sv(32'd200, 3'd6, "R7"); sv(32'd201, 3'd6, "R7"); sv(32'd150, 3'd6, "R7");
    // R8: mode change clears held state
    sv(32'd201, 3'd5, "R8");
    step(1'b0, 0, 3'd6, 1'b0, 1'b0, 1'b0, "R8");
    sv(32'd150, 3'd5, "R8");
    sv(32'd201, 3'd5, "R8");
    sv(32'd150, 3'd6, "R8");
    // R12: no strobe, no evaluation
    step(1'b0, 32'd50, 3'd6, 1'b0, 1'b0, 1'b0, "R12");
    step(1'b0, 32'd50, 3'd6, 1'b0, 1'b0, 1'b0, "R12");
    // R10 clear and set-wins
    step(1'b0, 0, 3'd1, 1'b1, 1'b0, 1'b0, "R10");
    step(1'b0, 0, 3'd1, 1'b0, 1'b0, 1'b0, "R10");
    sv(32'd150, 3'd1, "R10");
    step(1'b1, 32'd150, 3'd1, 1'b1, 1'b0, 1'b0, "R10");
    step(1'b0, 0, 3'd1, 1'b1, 1'b0, 1'b0, "R10");
    // R3: off mode
    step(1'b1, 32'd300, 3'd0, 1'b0, 1'b0, 1'b0, "R3");
    step(1'b1, 32'd5, 3'd0, 1'b0, 1'b0, 1'b0, "R3");
    // R9: event gating
    evtOutEn = 1'b0;
    sv(32'd150, 3'd3, "R9");
    evtOutEn = 1'b1;
    sv(32'd150, 3'd3, "R9");
    step(1'b0, 0, 3'd3, 1'b0, 1'b0, 1'b0, "R9");
    // R11: masking and clear-wins
    step(1'b0, 0, 3'd3, 1'b0, 1'b0, 1'b1, "R11");
    step(1'b0, 0, 3'd3, 1'b0, 1'b1, 1'b1, "R11");
    step(1'b0, 0, 3'd3, 1'b0, 1'b1, 1'b0, "R11");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] md;
      if (i % 37 == 0) begin
        lowThresh  = {8'($urandom), 24'($urandom % 2000)};
        highThresh = {8'($urandom), 24'($urandom % 2000)};
      end
      md = (i % 23 == 0) ? 3'($urandom) : mMode;
      evtOutEn = ($urandom % 4) != 0;
      step(($urandom % 2) == 1, pickNear(lowThresh, highThresh), md,
           ($urandom % 8) == 0, ($urandom % 16) == 0, ($urandom % 16) == 0, "R12");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule